// File: doc/BRIEF.md
# Debug Control Register Read Sequencer

This block sits on the target side of a 16-bit full-duplex debug word channel and handles one command: reading a control register on behalf of an external debugger. Every channel transfer moves one 16-bit word in from the host and one 17-bit response word out. The response is one status bit followed by 16 data bits. The response sent during a transfer is the one the sequencer prepared before that transfer began.

After the command word, the host sends a 32-bit register select as two words, upper half first. The sequencer then raises a request to the control-register file and holds it until the file acknowledges or flags an error. The host keeps clocking filler words during this time and gets "not ready" for each one. The sequencer then returns the register value as an upper word followed by a lower word. If the access faulted, it returns a single bus-error word in place of the data. The word that the host sends during the final response transfer is decoded as the next command, so reads can follow one another with no gap.

States:
- `ST_IDLE`: waiting for a command.
- `ST_SEL_HI` and `ST_SEL_LO`: taking in the two halves of the select.
- `ST_WAIT`: the register access is pending.
- `ST_DATA_HI` and `ST_DATA_LO`: returning the result.
- `ST_FAULT`: returning the bus error.

Transitions:
- An accepted command moves the sequencer from idle, data-low or fault to `ST_SEL_HI`.
- Any other word in those same states leaves it in `ST_IDLE` with an illegal-command response armed.
- Each select transfer advances the sequencer by one state.
- An error from the register file moves `ST_WAIT` to `ST_FAULT`. An acknowledge without an error moves it to `ST_DATA_HI`.
- A transfer in `ST_DATA_HI` advances to `ST_DATA_LO`.

Top module: `dbg_ctlreg_read_seq`

## Requirements
- R1: After reset the prepared response is not-ready (status 1, data 0x0000) and no register request is raised.
- R2: The command word (parameter CMD_CODE, default 0xC5A0) is accepted, the next two words are taken as select bits 31:16 and then 15:0, and the request presents that 32-bit select, unchanged, for as long as it is raised.
- R3: The transfers that carry the two select words, and every transfer made while the request is pending, return not-ready (1 + 0x0000).
- R4: The request stays raised until acknowledge or error is seen, and it drops in the cycle after that.
- R5: A successful read returns status 0 with data bits 31:16 on the first transfer that follows, then status 0 with bits 15:0 on the next transfer.
- R6: Result bits whose implemented-bit mask is 0 are returned as 0.
- R7: An error from the register file (error takes priority over acknowledge) makes the next response 1 + 0x0001, which replaces both data words.
- R8: The word received during the low-data transfer or the bus-error transfer is decoded as a new command, and a matching word starts a new read at once.
- R9: Any non-matching word received in idle, in the low-data transfer or in the bus-error transfer makes the next response 1 + 0xFFFF, and the sequencer stays idle, ready for a command on that next transfer.
- R10: Words received during select-high/low, pending and high-data transfers are never decoded as commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | One-cycle strobe: one word transfer takes place this cycle |
| rx_word | input | 16 | Word received from the host in this transfer |
| tx_word | output | 17 | Response for the current transfer: bit 16 status, bits 15:0 data |
| rf_req | output | 1 | Register-file read request |
| rf_sel | output | 32 | Register select presented with the request |
| rf_ack | input | 1 | Register file: read complete, data valid |
| rf_err | input | 1 | Register file: access faulted |
| rf_rdata | input | 32 | Register file read data |
| rf_mask | input | 32 | Register file implemented-bit mask for the selected register |

## Verification
The read path is exercised with three request latencies: immediate, three cycles and five cycles. Each latency has its own number of filler transfers, which confirms that not-ready covers the whole pending time and that the data arrives on the transfer after the acknowledge. A faulting read is followed directly by a pipelined command, and so is a good read. Together these show that the final transfer of either path takes in a command. A partially implemented register with all-ones read data shows that masking applies to both halves. Sending the command code during the high-data transfer, and non-matching words in idle and pipelined slots, tells apart states that decode commands from states that ignore input.

// File: rtl/dbg_rcr_pkg.sv
package dbg_rcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEL_HI  = 3'd1,
        ST_SEL_LO  = 3'd2,
        ST_WAIT    = 3'd3,
        ST_DATA_HI = 3'd4,
        ST_DATA_LO = 3'd5,
        ST_FAULT   = 3'd6
    } rcr_state_t;

    // Halves of a double-width quantity, in the order they cross the channel.
    localparam int NUM_HALVES = 2;

endpackage

// File: rtl/dbg_rcr_decode.sv
module dbg_rcr_decode #(
    parameter int                 WORD_W   = 16,
    parameter logic [WORD_W-1:0]  CMD_CODE = 16'hC5A0
) (
    input  logic [WORD_W-1:0] word_in,
    output logic              is_cmd
);

    always_comb begin
        is_cmd = (word_in == CMD_CODE);
    end

endmodule

// File: rtl/dbg_rcr_operand.sv
module dbg_rcr_operand
    import dbg_rcr_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int SEL_W = NUM_HALVES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [WORD_W-1:0] word_in,
    output logic [SEL_W-1:0]  sel_out
);

    logic [NUM_HALVES-1:0] load_vec;
    assign load_vec = {load_hi, load_lo};

    // Index 1 holds the upper half (arrives first), index 0 the lower half.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic [WORD_W-1:0] half_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (load_vec[h]) begin
                half_q <= word_in;
            end
        end
        assign sel_out[h*WORD_W +: WORD_W] = half_q;
    end

endmodule

// File: rtl/dbg_rcr_result.sv
module dbg_rcr_result #(
    parameter int WORD_W = 16,
    localparam int SEL_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [SEL_W-1:0]  rdata,
    input  logic [SEL_W-1:0]  mask,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] lo_word
);

    logic [SEL_W-1:0]  clean;
    logic [WORD_W-1:0] lo_q;

    always_comb begin
        clean = rdata & mask;
    end

    // The upper half goes straight into the response register; only the
    // lower half needs keeping until the following transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (capture) begin
            lo_q <= clean[WORD_W-1:0];
        end
    end

    assign hi_word = clean[SEL_W-1:WORD_W];
    assign lo_word = lo_q;

endmodule

// File: rtl/dbg_ctlreg_read_seq.sv
module dbg_ctlreg_read_seq
    import dbg_rcr_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] CMD_CODE = 16'hC5A0,
    localparam int SEL_W = 2 * WORD_W,
    localparam int RSP_W = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic [RSP_W-1:0]  tx_word,
    output logic              rf_req,
    output logic [SEL_W-1:0]  rf_sel,
    input  logic              rf_ack,
    input  logic              rf_err,
    input  logic [SEL_W-1:0]  rf_rdata,
    input  logic [SEL_W-1:0]  rf_mask
);

    localparam logic [RSP_W-1:0] RSP_NOT_READY = {1'b1, {WORD_W{1'b0}}};
    localparam logic [RSP_W-1:0] RSP_BUS_ERR   = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [RSP_W-1:0] RSP_ILLEGAL   = {1'b1, {WORD_W{1'b1}}};

    rcr_state_t        state_q, state_d;
    logic [RSP_W-1:0]  tx_q;
    logic              is_cmd;
    logic              done_ok, done_err;
    logic [WORD_W-1:0] res_hi, res_lo;

    dbg_rcr_decode #(.WORD_W(WORD_W), .CMD_CODE(CMD_CODE)) u_decode (
        .word_in (rx_word),
        .is_cmd  (is_cmd)
    );

    dbg_rcr_operand #(.WORD_W(WORD_W)) u_operand (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (xfer_valid && (state_q == ST_SEL_HI)),
        .load_lo (xfer_valid && (state_q == ST_SEL_LO)),
        .word_in (rx_word),
        .sel_out (rf_sel)
    );

    assign done_err = (state_q == ST_WAIT) && rf_err;
    assign done_ok  = (state_q == ST_WAIT) && rf_ack && !rf_err;

    dbg_rcr_result #(.WORD_W(WORD_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (done_ok),
        .rdata   (rf_rdata),
        .mask    (rf_mask),
        .hi_word (res_hi),
        .lo_word (res_lo)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DATA_LO, ST_FAULT: begin
                if (xfer_valid) state_d = is_cmd ? ST_SEL_HI : ST_IDLE;
            end
            ST_SEL_HI: begin
                if (xfer_valid) state_d = ST_SEL_LO;
            end
            ST_SEL_LO: begin
                if (xfer_valid) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rf_err)      state_d = ST_FAULT;
                else if (rf_ack) state_d = ST_DATA_HI;
            end
            ST_DATA_HI: begin
                if (xfer_valid) state_d = ST_DATA_LO;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: the response word prepared for the next transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= RSP_NOT_READY;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DATA_LO, ST_FAULT: begin
                    if (xfer_valid) tx_q <= is_cmd ? RSP_NOT_READY : RSP_ILLEGAL;
                end
                ST_SEL_HI, ST_SEL_LO: begin
                    if (xfer_valid) tx_q <= RSP_NOT_READY;
                end
                ST_WAIT: begin
                    if (done_err)     tx_q <= RSP_BUS_ERR;
                    else if (done_ok) tx_q <= {1'b0, res_hi};
                end
                ST_DATA_HI: begin
                    if (xfer_valid) tx_q <= {1'b0, res_lo};
                end
                default: tx_q <= RSP_NOT_READY;
            endcase
        end
    end

    assign tx_word = tx_q;
    assign rf_req  = (state_q == ST_WAIT);

endmodule

// File: rtl/dbg_ctlreg_read_seq_chk.sv
module dbg_ctlreg_read_seq_chk #(
    parameter int WORD_W = 16,
    localparam int SEL_W = 2 * WORD_W,
    localparam int RSP_W = WORD_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_valid,
    input logic [RSP_W-1:0] tx_word,
    input logic             rf_req,
    input logic [SEL_W-1:0] rf_sel,
    input logic             rf_ack,
    input logic             rf_err,
    input logic [SEL_W-1:0] rf_rdata,
    input logic [SEL_W-1:0] rf_mask
);

    localparam logic [RSP_W-1:0] C_NR   = {1'b1, {WORD_W{1'b0}}};
    localparam logic [RSP_W-1:0] C_BERR = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};

    // R4 / R2: request and select hold while nothing has answered
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_ack && !rf_err) |=> (rf_req && $stable(rf_sel)));

    // R4: request released right after an answer
    a_r4_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && (rf_ack || rf_err)) |=> !rf_req);

    // R3: not-ready while pending
    a_r3_nr_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> (tx_word == C_NR));

    // R7: fault becomes bus-error status
    a_r7_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_err) |=> (tx_word == C_BERR));

    // R5 / R6: upper masked half comes first with status 0
    a_r5_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_ack && !rf_err) |=>
        (tx_word == {1'b0, $past(rf_rdata[SEL_W-1:WORD_W] & rf_mask[SEL_W-1:WORD_W])}));

    // R9: status words carry only defined codes
    a_r9_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word[WORD_W] |-> ((tx_word[WORD_W-1:0] == '0) ||
                             (tx_word[WORD_W-1:0] == WORD_W'(1)) ||
                             (tx_word[WORD_W-1:0] == {WORD_W{1'b1}})));

    // R10: response changes only on a transfer or an answer to a request
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid && !rf_req) |=> $stable(tx_word));

endmodule

bind dbg_ctlreg_read_seq dbg_ctlreg_read_seq_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_dbg_ctlreg_read_seq.sv
module tb_dbg_ctlreg_read_seq;

    localparam logic [15:0] CMD  = 16'hC5A0;
    localparam logic [16:0] NR   = 17'h1_0000;
    localparam logic [16:0] BERR = 17'h1_0001;
    localparam logic [16:0] ILL  = 17'h1_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic [16:0] tx_word;
    logic        rf_req;
    logic [31:0] rf_sel;
    logic        rf_ack = 1'b0, rf_err = 1'b0;
    logic [31:0] rf_rdata = '0, rf_mask = '0;

    int total = 0;
    int bad = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    // register-file model settings
    logic [31:0] m_sel, m_data, m_mask;
    bit          m_err = 0;
    int          m_delay = 0;
    bit          rf_done = 0;

    always #5 clk = ~clk;

    dbg_ctlreg_read_seq dut (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .rx_word(rx_word),
        .tx_word(tx_word), .rf_req(rf_req), .rf_sel(rf_sel), .rf_ack(rf_ack),
        .rf_err(rf_err), .rf_rdata(rf_rdata), .rf_mask(rf_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one transfer, expected response queued for the monitor
    task automatic xfer(input logic [15:0] w, input logic [16:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        xfer_valid = 1'b1;
        rx_word    = w;
        @(negedge clk);
        xfer_valid = 1'b0;
        rx_word    = 16'h0000;
    endtask

    // monitor: compare the response seen during each transfer
    always @(negedge clk) begin
        #1;
        if (xfer_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", {15'd0, tx_word}, 32'd0);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(tx_word === e, t, {15'd0, tx_word}, {15'd0, e});
            end
        end
    end

    // register-file model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rf_req) begin
                check(rf_sel === m_sel, "R2 select presented", rf_sel, m_sel);
                repeat (m_delay) @(negedge clk);
                check(rf_req === 1'b1, "R4 request held", {31'd0, rf_req}, 32'd1);
                rf_ack   = !m_err;
                rf_err   = m_err;
                rf_rdata = m_data;
                rf_mask  = m_mask;
                @(negedge clk);
                rf_ack = 1'b0;
                rf_err = 1'b0;
                check(rf_req === 1'b0, "R4 request dropped", {31'd0, rf_req}, 32'd0);
                rf_done = 1'b1;
            end
        end
    end

    // sends the select (after the command transfer) and waits for the access
    task automatic select_and_wait(input logic [31:0] sel, input logic [31:0] data,
                                   input logic [31:0] mask, input bit err,
                                   input int dly, input int nfill);
        m_sel = sel; m_data = data; m_mask = mask; m_err = err; m_delay = dly;
        xfer(sel[31:16], NR, "R3 select high");
        xfer(sel[15:0],  NR, "R3 select low");
        for (int i = 0; i < nfill; i++) xfer(16'h0000, NR, "R3 pending filler");
        wait (rf_done == 1'b1);
        rf_done = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_word === NR, "R1 reset response", {15'd0, tx_word}, {15'd0, NR});
        check(rf_req === 1'b0, "R1 reset request", {31'd0, rf_req}, 32'd0);
        rst_n = 1'b1;

        // read 1: long latency, full mask
        xfer(CMD, NR, "R1 idle response on command");
        select_and_wait(32'h1234_5678, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0, 5, 2);
        xfer(CMD,      {1'b0, 16'hDEAD}, "R5 high word (R10 command ignored)");
        xfer(16'h0000, {1'b0, 16'hBEEF}, "R5 low word, R10 proof");
        // 0x0000 above was decoded (R8 slot) as illegal
        xfer(CMD, ILL, "R9 illegal status then idle");

        // read 2: fault, short latency
        select_and_wait(32'hA5A5_0003, 32'h0BAD_0BAD, 32'hFFFF_FFFF, 1'b1, 3, 1);
        xfer(CMD, BERR, "R7 bus error, R8 pipelined command");

        // read 3: immediate answer, partial mask
        select_and_wait(32'h0000_00FE, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b0, 0, 0);
        xfer(16'h1111, {1'b0, 16'h0000}, "R6 unimplemented high bits zero");
        xfer(CMD,      {1'b0, 16'h00FF}, "R6 masked low word, R8 pipelined");

        // read 4: after pipelined command
        select_and_wait(32'h0001_0002, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 2, 1);
        xfer(16'h0000, {1'b0, 16'h8000}, "R5 high word");
        xfer(16'h7777, {1'b0, 16'h0001}, "R5 low word");
        xfer(16'h7777, ILL, "R9 illegal after low word");
        xfer(16'h0000, ILL, "R9 illegal again in idle");
        xfer(CMD,      ILL, "R9 command accepted in illegal slot");
        select_and_wait(32'hFFFF_0000, 32'h1357_2468, 32'hFFFF_FFFF, 1'b0, 1, 0);
        xfer(16'h0000, {1'b0, 16'h1357}, "R5 high word");
        xfer(16'h0000, {1'b0, 16'h2468}, "R5 low word");
        xfer(16'h0000, ILL, "R9 idle illegal");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule